// File: doc/BRIEF.md
# Phase-Lock Throttle Error Generator

This block computes the prime-mover command for a generator that must follow a target voltage phasor in both frequency and phase. On every update strobe it takes the target and measured frequencies, the target and measured phase angles, a calibrated loop delay and a measured power value. It forms one error term, runs that term through a PID stage, adds a power feedforward, and registers a saturated throttle command. It also keeps a lock detector, which decides whether the phase part of the error is active.

The error is the frequency difference plus a phase term scaled by a fixed gain. Before the phase difference is taken, the target phase is moved forward by the angle the target frequency covers during the loop delay. The difference wraps to one turn. Until lock is held, the phase gain is zero and a small fixed offset is added to the frequency error, so the machine slips slowly toward alignment. The derivative part of the PID may never exceed a set fraction of the present error magnitude. The integrator stops accumulating while the summed output lies outside the command range.

Top module: `thr_lock_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `cmd` is 0, `cmd_vld` is 0 and `locked` is 0.
- R2: A strobe sampled at clock edge k yields a one-cycle `cmd_vld` pulse after edge k+1, and no pulse after edge k+2. `cmd` changes only together with that pulse. `locked` reflects the strobe's lock decision after edge k.
- R3: Frequencies are signed with 8 fractional bits (LSB 1/256 Hz). The error is target minus measured frequency, plus the phase term when locked, or plus the acquisition offset (default 64 LSB) when not locked.
- R4: When `locked` is 1 at the strobe, the phase term is (phase error × 5120) arithmetically shifted right by 16 bits. A quarter turn therefore adds 5 Hz.
- R5: Phases are 16-bit values in which 65536 counts make one turn. The phase error is (target + advance − measured) taken modulo 65536 and read as a signed number in [−32768, 32767].
- R6: The advance is (target frequency × `tc`) arithmetically shifted right by 16. `tc` is unsigned, with an LSB of 2^-24 s, so 425 µs is 7130.
- R7: Lock is set by the 64th consecutive strobe whose absolute phase error is below 364 counts (about 2°). Any strobe at or above that threshold restarts the count.
- R8: While locked, a strobe whose absolute phase error exceeds 1820 counts (about 10°) clears lock. So does any strobe with `lock_ok` low.
- R9: The acquisition offset is applied only while not locked.
- R10: The PID output is P = (e·256)>>>8 plus I = integ>>>8 plus D. D is ((e − e_prev)·128)>>>8, clamped to ±(|e|>>>1). e_prev is 0 after reset.
- R11: The feedforward term (power·256)>>>8 is added to the PID sum.
- R12: The command is the sum clamped to ±32767. The integrator adds e·16 on a strobe only when the sum is not clamped; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe, one cycle per computation |
| lock_ok | input | 1 | Permits lock; low forces unlocked |
| f_tgt | input | 24 | Target frequency, signed, 1/256 Hz |
| f_meas | input | 24 | Measured frequency, signed, 1/256 Hz |
| ph_tgt | input | 16 | Target phase, 65536 counts per turn |
| ph_meas | input | 16 | Measured phase, 65536 counts per turn |
| tc | input | 16 | Calibrated loop delay, unsigned, 2^-24 s |
| pwr | input | 24 | Measured power, signed, command units |
| cmd | output | 16 | Signed saturated throttle command |
| cmd_vld | output | 1 | One-cycle pulse when `cmd` is updated |
| locked | output | 1 | Phase lock held |

## Verification
A wrong lock count or threshold shows on `locked` one edge after the strobe that should have changed it. It then shifts every later `cmd`, because the phase term and the acquisition offset swap places. A bad derivative clamp, phase wrap or delay advance changes `cmd` on the very next `cmd_vld` pulse. An integrator that keeps winding up during saturation stays hidden while the output is clamped. It then shows as a wrong value on the first unclamped command after the saturating strobes, so the bench always follows saturation with in-range strobes.

// File: rtl/thr_lock_pkg.sv
package thr_lock_pkg;

    localparam int ACC_W = 48;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic vld;
        acc_t err;
    } stage_t;

    function automatic acc_t acc_abs(input acc_t v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic acc_t acc_clamp(input acc_t v, input acc_t lim);
        if (v > lim)       return lim;
        else if (v < -lim) return -lim;
        else               return v;
    endfunction

endpackage

// File: rtl/thr_phase_err.sv
module thr_phase_err #(
    parameter int FW    = 24,
    parameter int PW    = 16,
    parameter int TW    = 16,
    parameter int TC_SH = 16
) (
    input  logic signed [FW-1:0] f_tgt,
    input  logic        [PW-1:0] ph_tgt,
    input  logic        [PW-1:0] ph_meas,
    input  logic        [TW-1:0] tc,
    output logic signed [PW-1:0] pe,
    output logic        [PW-1:0] pe_mag
);
    localparam int AW = FW + TW + 1;

    logic signed [AW-1:0] adv_full;
    logic signed [AW-1:0] adv_sh;
    logic        [PW-1:0] diff;

    always_comb begin
        adv_full = AW'(f_tgt) * $signed({1'b0, tc});
        adv_sh   = adv_full >>> TC_SH;
        diff     = ph_tgt + adv_sh[PW-1:0] - ph_meas;
        pe       = $signed(diff);
        pe_mag   = pe[PW-1] ? (~diff + 1'b1) : diff;
    end
endmodule

// File: rtl/thr_lock_trk.sv
module thr_lock_trk #(
    parameter int PW       = 16,
    parameter int LOCK_N   = 64,
    parameter int LOCK_IN  = 364,
    parameter int LOCK_OUT = 1820
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          allow,
    input  logic [PW-1:0] pe_mag,
    output logic          locked
);
    localparam int CW = $clog2(LOCK_N + 1);

    logic [CW-1:0] cnt;
    logic          near, far;

    assign near = pe_mag < PW'(LOCK_IN);
    assign far  = pe_mag > PW'(LOCK_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            cnt    <= '0;
        end else if (stb) begin
            if (!allow) begin
                locked <= 1'b0;
                cnt    <= '0;
            end else if (locked) begin
                if (far) begin
                    locked <= 1'b0;
                    cnt    <= '0;
                end
            end else if (near) begin
                if (cnt == CW'(LOCK_N - 1)) begin
                    locked <= 1'b1;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // R7
    rise_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cnt) == CW'(LOCK_N - 1));

    // R8
    allow_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !allow) |=> !locked);

    // R8
    far_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && locked && far) |=> !locked);
endmodule

// File: rtl/thr_pid_core.sv
module thr_pid_core
    import thr_lock_pkg::*;
#(
    parameter int EW   = 26,
    parameter int PWRW = 24,
    parameter int OW   = 16,
    parameter int GSH  = 8,
    parameter int KP   = 256,
    parameter int KI   = 16,
    parameter int KD   = 128,
    parameter int DSH  = 1,
    parameter int KF   = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic signed [EW-1:0]   err,
    input  logic signed [PWRW-1:0] pwr,
    output logic signed [OW-1:0]   cmd,
    output logic                   cmd_vld
);
    localparam acc_t OMAX = acc_t'((64'sd1 <<< (OW - 1)) - 1);

    acc_t integ, e_prev;
    acc_t e_x, p_t, i_t, d_raw, d_lim, d_t, ff_t, sum, sum_c;
    logic sat;

    always_comb begin
        e_x   = acc_t'(err);
        p_t   = (e_x * acc_t'(KP)) >>> GSH;
        i_t   = integ >>> GSH;
        d_raw = ((e_x - e_prev) * acc_t'(KD)) >>> GSH;
        d_lim = acc_abs(e_x) >>> DSH;
        d_t   = acc_clamp(d_raw, d_lim);
        ff_t  = (acc_t'(pwr) * acc_t'(KF)) >>> GSH;
        sum   = p_t + i_t + d_t + ff_t;
        sat   = (sum > OMAX) || (sum < -OMAX);
        sum_c = acc_clamp(sum, OMAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ   <= '0;
            e_prev  <= '0;
            cmd     <= '0;
            cmd_vld <= 1'b0;
        end else begin
            cmd_vld <= in_vld;
            if (in_vld) begin
                cmd    <= sum_c[OW-1:0];
                e_prev <= e_x;
                if (!sat) integ <= integ + e_x * acc_t'(KI);
            end
        end
    end

    // R12
    windup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && sat) |=> $stable(integ));

    // R12
    cmd_range_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> (cmd != {1'b1, {(OW-1){1'b0}}}));

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(cmd));

    // R10
    dclamp_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> (acc_abs(d_t) <= d_lim));
endmodule

// File: rtl/thr_lock_top.sv
module thr_lock_top
    import thr_lock_pkg::*;
#(
    parameter int FW       = 24,
    parameter int PW       = 16,
    parameter int TW       = 16,
    parameter int PWRW     = 24,
    parameter int OW       = 16,
    parameter int TC_SH    = 16,
    parameter int KPH      = 5120,
    parameter int ACQ      = 64,
    parameter int LOCK_N   = 64,
    parameter int LOCK_IN  = 364,
    parameter int LOCK_OUT = 1820,
    parameter int GSH      = 8,
    parameter int KP       = 256,
    parameter int KI       = 16,
    parameter int KD       = 128,
    parameter int DSH      = 1,
    parameter int KF       = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  logic                   lock_ok,
    input  logic signed [FW-1:0]   f_tgt,
    input  logic signed [FW-1:0]   f_meas,
    input  logic        [PW-1:0]   ph_tgt,
    input  logic        [PW-1:0]   ph_meas,
    input  logic        [TW-1:0]   tc,
    input  logic signed [PWRW-1:0] pwr,
    output logic signed [OW-1:0]   cmd,
    output logic                   cmd_vld,
    output logic                   locked
);
    localparam int EW = FW + 2;

    logic signed [PW-1:0] pe;
    logic        [PW-1:0] pe_mag;
    acc_t                 ph_term, err_c;
    stage_t               s1;

    thr_phase_err #(.FW(FW), .PW(PW), .TW(TW), .TC_SH(TC_SH)) u_pe (
        .f_tgt(f_tgt), .ph_tgt(ph_tgt), .ph_meas(ph_meas), .tc(tc),
        .pe(pe), .pe_mag(pe_mag)
    );

    thr_lock_trk #(.PW(PW), .LOCK_N(LOCK_N), .LOCK_IN(LOCK_IN),
                   .LOCK_OUT(LOCK_OUT)) u_lock (
        .clk(clk), .rst(rst), .stb(upd), .allow(lock_ok),
        .pe_mag(pe_mag), .locked(locked)
    );

    always_comb begin
        ph_term = (acc_t'(pe) * acc_t'(KPH)) >>> PW;
        err_c   = acc_t'(f_tgt) - acc_t'(f_meas)
                + (locked ? ph_term : acc_t'(ACQ));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= upd;
            if (upd) s1.err <= err_c;
        end
    end

    thr_pid_core #(.EW(EW), .PWRW(PWRW), .OW(OW), .GSH(GSH), .KP(KP),
                   .KI(KI), .KD(KD), .DSH(DSH), .KF(KF)) u_pid (
        .clk(clk), .rst(rst), .in_vld(s1.vld), .err(s1.err[EW-1:0]),
        .pwr(pwr), .cmd(cmd), .cmd_vld(cmd_vld)
    );

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> $past(upd, 2));
endmodule

// File: tb/sim_thr_lock_top.sv
module sim_thr_lock_top;
    logic clk = 1'b0;
    logic rst, upd, lock_ok;
    logic signed [23:0] f_tgt, f_meas, pwr;
    logic [15:0] ph_tgt, ph_meas, tc;
    logic signed [15:0] cmd;
    logic cmd_vld, locked;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    longint m_integ, m_eprev;
    bit     m_locked;
    int     m_cnt;

    always #2 clk = ~clk;

    thr_lock_top u0 (
        .clk(clk), .rst(rst), .upd(upd), .lock_ok(lock_ok),
        .f_tgt(f_tgt), .f_meas(f_meas), .ph_tgt(ph_tgt), .ph_meas(ph_meas),
        .tc(tc), .pwr(pwr), .cmd(cmd), .cmd_vld(cmd_vld), .locked(locked)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v, input longint l);
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    task automatic do_reset();
        rst = 1; upd = 0; lock_ok = 1; f_tgt = 0; f_meas = 0;
        ph_tgt = 0; ph_meas = 0; tc = 0; pwr = 0;
        repeat (3) @(negedge clk);
        chk("R1 cmd", cmd, 0); chk("R1 vld", cmd_vld, 0); chk("R1 locked", locked, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 cmd after", cmd, 0); chk("R1 locked after", locked, 0);
        m_integ = 0; m_eprev = 0; m_locked = 0; m_cnt = 0;
    endtask

    // one strobe with reference model; returns expected command
    task automatic stb(input longint ft, input longint fm, input longint pt,
                       input longint pm, input longint tcv, input longint pw,
                       input bit allow, input string tag, output longint ecmd);
        longint raw, pe, mag, e, p, i, d, dl, ff, s;
        logic signed [15:0] w;
        bit old_l;
        f_tgt = 24'(ft); f_meas = 24'(fm); ph_tgt = 16'(pt); ph_meas = 16'(pm);
        tc = 16'(tcv); pwr = 24'(pw); lock_ok = allow; upd = 1;
        raw = pt + ((ft * tcv) >>> 16) - pm;
        w = raw[15:0]; pe = w; mag = (pe < 0) ? -pe : pe;
        old_l = m_locked;
        if (!allow) begin m_locked = 0; m_cnt = 0; end
        else if (m_locked) begin if (mag > 1820) begin m_locked = 0; m_cnt = 0; end end
        else if (mag < 364) begin
            if (m_cnt == 63) begin m_locked = 1; m_cnt = 0; end else m_cnt++;
        end else m_cnt = 0;
        e = ft - fm + (old_l ? ((pe * 5120) >>> 16) : 64);
        p = (e * 256) >>> 8; i = m_integ >>> 8;
        dl = ((e < 0) ? -e : e) >>> 1;
        d = clampv(((e - m_eprev) * 128) >>> 8, dl);
        ff = (pw * 256) >>> 8;
        s = p + i + d + ff;
        if (s <= 32767 && s >= -32767) m_integ += e * 16;
        m_eprev = e;
        ecmd = clampv(s, 32767);
        @(posedge clk); @(negedge clk);
        upd = 0;
        chk({"R2 no early vld ", tag}, cmd_vld, 0);
        chk({"locked ", tag}, locked, m_locked);
        @(posedge clk); @(negedge clk);
        chk({"R2 vld ", tag}, cmd_vld, 1);
        chk({"cmd ", tag}, cmd, ecmd);
    endtask

    task automatic t_basic();
        longint c;
        do_reset();
        // R3 R9: unlocked, error = 164 -> P 164, D 82
        stb(12800, 12700, 0, 0, 0, 0, 1, "R3", c);
        chk("R3 hand", cmd, 246);
        @(negedge clk);
        chk("R2 single pulse", cmd_vld, 0);
        chk("R2 cmd held", cmd, 246);
    endtask

    task automatic t_dclamp();
        longint c;
        do_reset();
        stb(936, 0, 0, 0, 0, 0, 1, "R10 step", c);
        chk("R10 hand1", cmd, 1500);
        stb(36, 0, 0, 0, 0, 0, 1, "R10 fall", c);
        chk("R10 hand2 clamped", cmd, 112);
        stb(936, 0, 0, 0, 0, 0, 1, "R10 rise", c);
    endtask

    task automatic t_acquire();
        longint c;
        do_reset();
        for (int k = 0; k < 30; k++) stb(12800, 12800, 100, 100, 0, 0, 1, "R7 pre", c);
        stb(12800, 12800, 1010, 100, 0, 0, 1, "R7 miss", c);
        for (int k = 0; k < 63; k++) stb(12800, 12800, 100, 100, 0, 0, 1, "R7 count", c);
        chk("R7 not yet", locked, 0);
        stb(12800, 12800, 100, 100, 0, 0, 1, "R7 final", c);
        chk("R7 locked", locked, 1);
        stb(12800, 12800, 100, 100, 0, 0, 1, "R9 no offset", c);
    endtask

    task automatic t_phase();
        longint c;
        // assumes locked
        stb(12800, 12800, 1600, 100, 0, 0, 1, "R4 term", c);
        chk("R8 keep 8deg", locked, 1);
        stb(12800, 12800, 32512, 33024, 0, 0, 1, "R5 wrap", c);
        chk("R5 keep", locked, 1);
        stb(12800, 12800, 5000, 6392, 7130, 0, 1, "R6 advance", c);
        chk("R6 keep", locked, 1);
        stb(12800, 12800, 16484, 100, 0, 0, 1, "R4 quarter", c);
        chk("R8 far drop", locked, 0);
    endtask

    task automatic t_drop();
        longint c;
        for (int k = 0; k < 64; k++) stb(12800, 12790, 0, 0, 0, 0, 1, "R7 relock", c);
        chk("R7 relocked", locked, 1);
        stb(12800, 12790, 0, 0, 0, 0, 0, "R8 allow", c);
        chk("R8 allow drop", locked, 0);
    endtask

    task automatic t_ff_sat();
        longint c;
        do_reset();
        stb(12800, 12800, 0, 0, 0, 3000, 1, "R11 ff", c);
        stb(12800, 12800, 0, 0, 0, -2000, 1, "R11 ff neg", c);
        for (int k = 0; k < 4; k++) stb(212800, 12800, 0, 0, 0, 0, 1, "R12 pos", c);
        chk("R12 hand max", cmd, 32767);
        for (int k = 0; k < 3; k++) stb(12800, 212800, 0, 0, 0, 0, 1, "R12 neg", c);
        chk("R12 hand min", cmd, -32767);
        for (int k = 0; k < 3; k++) stb(13000, 12800, 0, 0, 0, 0, 1, "R12 unwind", c);
    endtask

    initial begin
        t_basic();
        t_dclamp();
        t_acquire();
        t_phase();
        t_drop();
        t_ff_sat();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule